// File: doc/BRIEF.md
# Merging Write Buffer

This block sits between a write-through cache and memory. It takes processor stores so that the processor can move on at once, and it holds them until memory accepts them. Each slot covers one block-aligned address. A slot keeps one data word per word position and a mask that marks which of those words have been written. When a store arrives, its block address is compared with every occupied slot. A store that hits a slot other than the oldest one is folded into that slot: it sets the word's mask bit and replaces any earlier data for that word. Any other store takes a fresh slot at the tail of the ring.

The memory side presents the oldest slot as one block write, with block address, all word lanes and the word mask. The slot is retired when memory accepts it. The oldest slot never takes a merge, so the block on the memory port stays the same until it is accepted. A read-check port lets a load look into the buffer before it goes to memory. It reports whether the addressed word is held and, if so, returns the youngest copy.

Top module: `merge_wbuf`

## Requirements
- R1: After synchronous reset the buffer is empty: `mem_valid` is 0, `st_ready` is 1 and `rd_hit` is 0.
- R2: A store is accepted in a cycle where `st_valid` and `st_ready` are both 1. The word address `st_addr` splits into a block address `st_addr[ADDR_W-1:OFF_W]` and a word offset `st_addr[OFF_W-1:0]`. If the store does not merge, it takes a new slot that holds only that word.
- R3: A store whose block matches an occupied slot other than the oldest one merges into that slot. It sets mask bit `offset` and overwrites that word's data, and no new slot is used.
- R4: A store whose block matches only the oldest slot does not merge. It takes a new slot, and the oldest slot's mask and data are left unchanged.
- R5: `mem_valid` is 1 whenever at least one slot is occupied. The port then shows the oldest slot: `mem_blk` is its block address, `mem_mask` bit i is set when word i was written, and word i is on `mem_data[i*DATA_W +: DATA_W]`. Lanes whose mask bit is 0 carry no defined value. Slots leave in the order they were allocated, one per cycle in which `mem_valid` and `mem_ready` are both 1.
- R6: While `mem_valid` is 1 and `mem_ready` is 0, `mem_blk`, `mem_mask` and `mem_data` hold their values into the next cycle.
- R7: `st_ready` depends combinationally on `st_addr`. It is 1 when fewer than DEPTH slots are occupied, or when the store would merge (R3). It is 0 when all slots are occupied and no slot other than the oldest matches.
- R8: `rd_hit` is 1 when some occupied slot matches the block of `rd_addr` and has the mask bit for its word offset set. `rd_data` is then the word from the youngest such slot. Both outputs are combinational.
- R9: In a cycle with both an accepted store and a drain handshake, both take effect: the oldest slot is retired and the store merges or allocates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store can be accepted this cycle |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store data word |
| mem_valid | output | 1 | Oldest slot offered to memory |
| mem_ready | input | 1 | Memory accepts the offered block write |
| mem_blk | output | BLK_W | Block address of the offered write |
| mem_data | output | WORDS*DATA_W | Word lanes of the offered write, word i at lane i |
| mem_mask | output | WORDS | Written-word mask of the offered write |
| rd_addr | input | ADDR_W | Word address to look up |
| rd_hit | output | 1 | Addressed word is held in the buffer |
| rd_data | output | DATA_W | Youngest buffered copy of the addressed word |

## Verification
The hardest situation to reach is a store to the block that is waiting on the memory port while a younger slot for the same block also exists. Here the merge has to skip the oldest slot, and a read has to return the younger copy. The stimulus holds `mem_ready` low and stores to one block several times in a row. It then fills every slot and offers both a store that would need a new slot and one that can merge. After that, a long mixed run draws addresses from only four blocks with random drain back-pressure, so that duplicate blocks, full-buffer stalls and same-cycle store-and-drain come up many times.

// File: rtl/mwb_pkg.sv
package mwb_pkg;
    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 32;
    localparam int WORDS     = 4;
    localparam int OFF_W     = $clog2(WORDS);
    localparam int BLK_W     = ADDR_W - OFF_W;
    localparam int DEPTH_DEF = 4;

    typedef logic [ADDR_W-1:0] waddr_t;
    typedef logic [BLK_W-1:0]  blk_t;
    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic                          valid;
        blk_t                          blk;
        logic [WORDS-1:0]              mask;
        logic [WORDS-1:0][DATA_W-1:0]  data;
    } slot_t;

    function automatic blk_t blk_of(waddr_t a);
        return a[ADDR_W-1:OFF_W];
    endfunction

    function automatic off_t off_of(waddr_t a);
        return a[OFF_W-1:0];
    endfunction

    function automatic logic [WORDS-1:0] word_sel(off_t o);
        return WORDS'(1) << o;
    endfunction
endpackage

// File: rtl/mwb_slot.sv
module mwb_slot
    import mwb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  alloc_i,
    input  logic  merge_i,
    input  logic  free_i,
    input  blk_t  blk_i,
    input  off_t  off_i,
    input  word_t data_i,
    output slot_t q
);
    // R2 fresh slot, R3 word merge, R5 retire on drain
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            if (free_i) begin
                q.valid <= 1'b0;
                q.mask  <= '0;
            end
            if (alloc_i) begin
                q.valid       <= 1'b1;
                q.blk         <= blk_i;
                q.mask        <= word_sel(off_i);
                q.data[off_i] <= data_i;
            end else if (merge_i) begin
                q.mask[off_i] <= 1'b1;
                q.data[off_i] <= data_i;
            end
        end
    end
endmodule

// File: rtl/mwb_match.sv
module mwb_match
    import mwb_pkg::*;
#(
    parameter int DEPTH = DEPTH_DEF,
    parameter int PTR_W = 2
) (
    input  slot_t [DEPTH-1:0] slots,
    input  logic [PTR_W-1:0]  head,
    input  blk_t              blk,
    output logic              hit,
    output logic [PTR_W-1:0]  idx
);
    // R3/R4: the oldest slot is never a merge target
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (slots[i].valid && slots[i].blk == blk && PTR_W'(i) != head) begin
                hit = 1'b1;
                idx = PTR_W'(i);
            end
        end
    end
endmodule

// File: rtl/mwb_lookup.sv
module mwb_lookup
    import mwb_pkg::*;
#(
    parameter int DEPTH = DEPTH_DEF,
    parameter int PTR_W = 2
) (
    input  slot_t [DEPTH-1:0] slots,
    input  logic [PTR_W-1:0]  head,
    input  waddr_t            addr,
    output logic              hit,
    output word_t             data
);
    logic [PTR_W-1:0] idx;

    // R8: scan oldest to youngest, later matches override earlier ones
    always_comb begin
        hit  = 1'b0;
        data = '0;
        idx  = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = PTR_W'((int'(head) + k) % DEPTH);
            if (slots[idx].valid && slots[idx].blk == blk_of(addr)
                && slots[idx].mask[off_of(addr)]) begin
                hit  = 1'b1;
                data = slots[idx].data[off_of(addr)];
            end
        end
    end
endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf
    import mwb_pkg::*;
#(
    parameter int DEPTH = DEPTH_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    st_valid,
    output logic                    st_ready,
    input  logic [ADDR_W-1:0]       st_addr,
    input  logic [DATA_W-1:0]       st_data,
    output logic                    mem_valid,
    input  logic                    mem_ready,
    output logic [BLK_W-1:0]        mem_blk,
    output logic [WORDS*DATA_W-1:0] mem_data,
    output logic [WORDS-1:0]        mem_mask,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic                    rd_hit,
    output logic [DATA_W-1:0]       rd_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    slot_t [DEPTH-1:0] slot_q;
    logic [PTR_W-1:0]  head, tail, mg_idx;
    logic [CNT_W-1:0]  cnt;
    logic              mg_hit, do_st, do_merge, do_alloc, do_pop;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    mwb_match #(.DEPTH(DEPTH), .PTR_W(PTR_W)) match_i (
        .slots (slot_q),
        .head  (head),
        .blk   (blk_of(st_addr)),
        .hit   (mg_hit),
        .idx   (mg_idx)
    );

    mwb_lookup #(.DEPTH(DEPTH), .PTR_W(PTR_W)) lookup_i (
        .slots (slot_q),
        .head  (head),
        .addr  (rd_addr),
        .hit   (rd_hit),
        .data  (rd_data)
    );

    // R7: room for a new slot, or a merge target exists
    assign st_ready = mg_hit || (cnt != CNT_W'(DEPTH));
    assign do_st    = st_valid && st_ready;
    assign do_merge = do_st && mg_hit;
    assign do_alloc = do_st && !mg_hit;

    // R5: oldest slot on the memory port
    assign mem_valid = (cnt != '0);
    assign mem_blk   = slot_q[head].blk;
    assign mem_mask  = slot_q[head].mask;
    assign mem_data  = slot_q[head].data;
    assign do_pop    = mem_valid && mem_ready;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            mwb_slot slot_i (
                .clk     (clk),
                .rst     (rst),
                .alloc_i (do_alloc && tail == PTR_W'(g)),
                .merge_i (do_merge && mg_idx == PTR_W'(g)),
                .free_i  (do_pop && head == PTR_W'(g)),
                .blk_i   (blk_of(st_addr)),
                .off_i   (off_of(st_addr)),
                .data_i  (st_data),
                .q       (slot_q[g])
            );
        end
    endgenerate

    // R9: allocation and retirement move independent pointers
    always_ff @(posedge clk) begin
        if (rst) begin
            head <= '0;
            tail <= '0;
            cnt  <= '0;
        end else begin
            if (do_alloc) tail <= bump(tail);
            if (do_pop)   head <= bump(head);
            case ({do_alloc, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/mwb_chk.sv
module mwb_chk
    import mwb_pkg::*;
#(
    parameter int DEPTH = DEPTH_DEF,
    parameter int PTR_W = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    st_valid,
    input logic                    st_ready,
    input logic                    mem_valid,
    input logic                    mem_ready,
    input logic [BLK_W-1:0]        mem_blk,
    input logic [WORDS-1:0]        mem_mask,
    input logic [WORDS*DATA_W-1:0] mem_data,
    input slot_t [DEPTH-1:0]       slot_q,
    input logic [PTR_W-1:0]        head
);
    logic [DEPTH-1:0] vld;
    logic             dup;

    always_comb begin
        dup = 1'b0;
        for (int i = 0; i < DEPTH; i++) vld[i] = slot_q[i].valid;
        for (int i = 0; i < DEPTH; i++)
            for (int j = i + 1; j < DEPTH; j++)
                if (slot_q[i].valid && slot_q[j].valid && PTR_W'(i) != head
                    && PTR_W'(j) != head && slot_q[i].blk == slot_q[j].blk)
                    dup = 1'b1;
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_blk)
                                    && $stable(mem_mask) && $stable(mem_data)); // R6

    AST_ROOM_READY: assert property (@(posedge clk) disable iff (rst)
        ($countones(vld) < DEPTH) |-> st_ready); // R7

    AST_NO_DUP_YOUNG: assert property (@(posedge clk) disable iff (rst)
        !dup); // R3

    AST_DRAIN_FREES: assert property (@(posedge clk) disable iff (rst)
        mem_valid && mem_ready && !st_valid |=> $countones(vld) == $past($countones(vld)) - 1); // R5

    AST_MASK_NONZERO: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> mem_mask != '0); // R5
endmodule

bind merge_wbuf mwb_chk #(.DEPTH(DEPTH), .PTR_W(PTR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .st_valid  (st_valid),
    .st_ready  (st_ready),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_blk   (mem_blk),
    .mem_mask  (mem_mask),
    .mem_data  (mem_data),
    .slot_q    (slot_q),
    .head      (head)
);

// File: tb/merge_wbuf_tb_top.sv
module merge_wbuf_tb_top;
    import mwb_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam int LW         = WORDS * DATA_W;

    logic clk, rst, st_valid, st_ready, mem_valid, mem_ready, rd_hit;
    logic [ADDR_W-1:0] st_addr, rd_addr;
    logic [DATA_W-1:0] st_data, rd_data;
    logic [BLK_W-1:0]  mem_blk;
    logic [LW-1:0]     mem_data;
    logic [WORDS-1:0]  mem_mask;

    merge_wbuf #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_data(st_data), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_blk(mem_blk), .mem_data(mem_data),
        .mem_mask(mem_mask), .rd_addr(rd_addr), .rd_hit(rd_hit), .rd_data(rd_data)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD / 2) clk = ~clk;
    end

    int    n_chk, n_fail;
    string phase;
    slot_t mq[$];

    task automatic chk(input string req, input logic [LW-1:0] act,
                       input logic [LW-1:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s [%s] %s: actual %0h expected %0h", req, phase, what, act, exp);
        end
    endtask

    function automatic waddr_t mk(int b, int w);
        return waddr_t'((b << OFF_W) | w);
    endfunction

    function automatic int find_merge(blk_t b);
        for (int j = 1; j < mq.size(); j++)
            if (mq[j].blk == b) return j;
        return -1;
    endfunction

    function automatic bit m_ready(waddr_t a);
        return (find_merge(blk_of(a)) >= 0) || (mq.size() < DEPTH);
    endfunction

    task automatic compare();
        bit    eh;
        word_t ed;
        chk("R7", LW'(st_ready), LW'(m_ready(st_addr)), "st_ready");
        chk("R5", LW'(mem_valid), LW'(mq.size() > 0), "mem_valid");
        if (mq.size() > 0) begin
            chk("R5", LW'(mem_blk), LW'(mq[0].blk), "mem_blk");
            chk("R5", LW'(mem_mask), LW'(mq[0].mask), "mem_mask");
            for (int w = 0; w < WORDS; w++)
                if (mq[0].mask[w])
                    chk("R5", LW'(mem_data[w*DATA_W +: DATA_W]), LW'(mq[0].data[w]), "mem_data lane");
        end
        eh = 1'b0;
        ed = '0;
        for (int j = 0; j < mq.size(); j++)
            if (mq[j].blk == blk_of(rd_addr) && mq[j].mask[off_of(rd_addr)]) begin
                eh = 1'b1;
                ed = mq[j].data[off_of(rd_addr)];
            end
        chk("R8", LW'(rd_hit), LW'(eh), "rd_hit");
        if (eh) chk("R8", LW'(rd_data), LW'(ed), "rd_data");
    endtask

    task automatic step(input bit sv, input waddr_t sa, input word_t sd,
                        input bit mr, input waddr_t ra);
        bit    acc, pop;
        int    j;
        slot_t e;
        st_valid = sv; st_addr = sa; st_data = sd; mem_ready = mr; rd_addr = ra;
        @(negedge clk);
        compare();
        acc = sv && m_ready(sa);
        pop = mr && (mq.size() > 0);
        j   = find_merge(blk_of(sa));
        @(posedge clk);
        if (acc && j >= 0) begin
            e = mq[j];
            e.mask[off_of(sa)] = 1'b1;
            e.data[off_of(sa)] = sd;
            mq[j] = e;
        end
        if (pop) void'(mq.pop_front());
        if (acc && j < 0) begin
            e = '0;
            e.valid = 1'b1;
            e.blk   = blk_of(sa);
            e.mask  = word_sel(off_of(sa));
            e.data[off_of(sa)] = sd;
            mq.push_back(e);
        end
        #1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        n_chk = 0; n_fail = 0; phase = "reset";
        rst = 1'b1; st_valid = 1'b0; st_addr = '0; st_data = '0;
        mem_ready = 1'b0; rd_addr = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R1", LW'(mem_valid), '0, "mem_valid after reset");
        chk("R1", LW'(st_ready), LW'(1), "st_ready after reset");
        chk("R1", LW'(rd_hit), '0, "rd_hit after reset");
        @(posedge clk); #1;

        phase = "R2 allocate";
        step(1, mk(16, 0), 32'h0000_00A0, 0, mk(16, 0));
        chk("R2", LW'(mem_mask), LW'(4'b0001), "first slot mask");

        phase = "R4 oldest not merged";
        step(1, mk(16, 1), 32'h0000_00A1, 0, mk(16, 1));
        chk("R4", LW'(mem_mask), LW'(4'b0001), "oldest mask unchanged");

        phase = "R3 merge";
        step(1, mk(16, 2), 32'h0000_00A2, 0, mk(16, 2));
        step(1, mk(16, 2), 32'h0000_00B2, 0, mk(16, 2));
        step(1, mk(16, 1), 32'h0000_00C1, 0, mk(16, 1));
        rd_addr = mk(16, 1); #1;
        chk("R3", LW'(rd_data), LW'(32'hC1), "merged word overwritten");
        rd_addr = mk(16, 0); #1;
        chk("R8", LW'(rd_data), LW'(32'hA0), "word only in oldest slot");

        phase = "R7 full";
        step(1, mk(17, 3), 32'h0000_0B03, 0, mk(17, 3));
        step(1, mk(18, 0), 32'h0000_0C00, 0, mk(18, 0));
        for (int i = 0; i < 3; i++) step(1, mk(19, 1), 32'h0000_0D01, 0, mk(19, 1));
        st_addr = mk(19, 1); #1;
        chk("R7", LW'(st_ready), '0, "full, no merge target");
        step(1, mk(16, 3), 32'h0000_00A3, 0, mk(16, 3));

        phase = "R6 stall drain";
        for (int i = 0; i < 10; i++) step(0, '0, '0, i[0], mk(16, i % 4));

        phase = "R9 store with drain";
        step(1, mk(20, 0), 32'h1111_0000, 0, mk(20, 0));
        step(1, mk(21, 2), 32'h2222_0002, 0, mk(21, 2));
        step(1, mk(20, 1), 32'h3333_0001, 1, mk(20, 1));
        step(1, mk(21, 3), 32'h4444_0003, 1, mk(21, 3));
        step(1, mk(22, 0), 32'h5555_0000, 1, mk(21, 3));

        phase = "mixed";
        for (int i = 0; i < 600; i++)
            step(($urandom % 4) != 0, mk(8 + ($urandom % 4), $urandom % WORDS),
                 $urandom, ($urandom % 3) == 0, mk(8 + ($urandom % 4), $urandom % WORDS));

        phase = "final drain";
        for (int i = 0; i < DEPTH + 2; i++) step(0, '0, '0, 1, '0);
        @(negedge clk);
        chk("R5", LW'(mem_valid), '0, "empty after drain");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule